// File: doc/BRIEF.md
# Time-Sliced Shared RAM Arbiter

A group of cores shares one central 32-bit RAM, and this block gives each core access to it in turn. A free-running slot counter passes a single access slot from core to core. With the default eight cores, each core owns exactly one clock in every eight. The slot does not depend on demand: no core can take another core's slot or lend its own.

Each core has its own request port. The port carries a byte address, write data, an access size (byte, halfword or word) and a write flag. A core raises its request and holds it. When its slot arrives, the access reaches the RAM. In the next cycle the core sees a one-cycle completion strobe, together with the read data if the access was a read. Byte and halfword accesses are steered onto the right byte lanes of the 32-bit word. Writes use byte enables, and reads are shifted down and zero-extended.

The RAM is held inside the block as a parameterised array. `ADDR_W` sets its size: 16 gives a 64 KB RAM of 16K words, and the default of 12 keeps elaboration small. The number of cores is set by `N_PORTS`, and the rotation length always equals that count. The asynchronous active-low reset is released into the block through a two-flop synchroniser.

Top module: `tsa_arbiter`

## Requirements
- R1: While reset is asserted, and until the first service after reset, every completion strobe is low and every read-data output is zero.
- R2: After reset is released, core 0 owns the first slot. The slots then pass to cores 1, 2, and so on up to N_PORTS-1, and then back to core 0.
- R3: The rotation length equals N_PORTS. A core that holds its request high continuously completes once every N_PORTS clocks.
- R4: At most one completion strobe is high in any cycle. A core's strobe rises only in the cycle after a slot that the core owned while its request was high.
- R5: A request completes at most N_PORTS clocks after it is raised. The completion strobe lasts one cycle, and the request stalls until then.
- R6: The size field is 2 bits: 00 selects a byte, 01 a halfword, 10 a word, and 11 is handled as a word. A word access uses address bits [ADDR_W-1:2] and ignores bits [1:0].
- R7: A byte access uses address bits [1:0] to pick lane k, which is RAM bits [8k+7:8k]. A byte write changes only that lane. A byte read returns the lane in bits [7:0], with bits [31:8] zero.
- R8: A halfword access uses address bit 1 to pick a half: 0 selects bits [15:0] and 1 selects bits [31:16]. Address bit 0 is ignored. A halfword write changes only those two lanes, and a halfword read returns them in bits [15:0] with bits [31:16] zero.
- R9: A core's read-data output is zero except in the cycle in which that core's strobe completes a read. Write completions return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_PORTS | Per-core request, held until done |
| we_i | input | N_PORTS | Per-core write flag (1 = write) |
| size_i | input | 2*N_PORTS | Per-core access size, core p at bits [2p+1:2p] |
| addr_i | input | N_PORTS*ADDR_W | Per-core byte address, core p at slice p |
| wdata_i | input | N_PORTS*32 | Per-core write data, right-aligned |
| rdata_o | output | N_PORTS*32 | Per-core read data, zero-extended |
| done_o | output | N_PORTS | Per-core one-cycle completion strobe |

## Verification
The hardest case to reach is a request that rises just after its own slot has passed. That request must wait out the full rotation while the other cores complete in the slots between. It must still finish within N_PORTS clocks and must leave no strobe on any other port. The bench raises requests on random cores in random cycles, so every arrival phase relative to the slot counter occurs many times. A directed case holds one request high across several rotations to measure the completion spacing. Lane steering is driven with mixed byte, halfword and word traffic, including misaligned low address bits, on a small address window. Different sizes therefore overlap the same words.

// File: rtl/tsa_pkg.sv
`timescale 1ns/1ps
package tsa_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;

  // Byte-enable mask for one access.
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: lane_mask = 4'b0001 << off;
      SZ_HALF: lane_mask = off[1] ? 4'b1100 : 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  // Replicate right-aligned write data onto every candidate lane.
  function automatic logic [WORD_W-1:0] lane_spread(input logic [1:0] sz, input logic [WORD_W-1:0] wd);
    case (sz)
      SZ_BYTE: lane_spread = {4{wd[7:0]}};
      SZ_HALF: lane_spread = {2{wd[15:0]}};
      default: lane_spread = wd;
    endcase
  endfunction

  // Shift the addressed lanes down and zero-extend.
  function automatic logic [WORD_W-1:0] lane_pick(input logic [1:0] sz, input logic [1:0] off,
                                                  input logic [WORD_W-1:0] q);
    logic [WORD_W-1:0] sh;
    sh = q >> {off, 3'b000};
    case (sz)
      SZ_BYTE: lane_pick = {24'h0, sh[7:0]};
      SZ_HALF: lane_pick = off[1] ? {16'h0, q[31:16]} : {16'h0, q[15:0]};
      default: lane_pick = q;
    endcase
  endfunction
endpackage

// File: rtl/tsa_slot_ctr.sv
`timescale 1ns/1ps
module tsa_slot_ctr #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned SLOT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_d;

  always_comb begin
    if (slot_q == SLOT_W'(N_PORTS - 1)) begin
      slot_d = '0;
    end else begin
      slot_d = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_d;
    end
  end

  assign slot_o = slot_q;
endmodule

// File: rtl/tsa_port_mux.sv
`timescale 1ns/1ps
module tsa_port_mux #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned SLOT_W  = 3
) (
  input  logic [SLOT_W-1:0]                   slot_i,
  input  logic [N_PORTS-1:0]                  req_i,
  input  logic [N_PORTS-1:0]                  we_i,
  input  logic [2*N_PORTS-1:0]                size_i,
  input  logic [N_PORTS*ADDR_W-1:0]           addr_i,
  input  logic [N_PORTS*tsa_pkg::WORD_W-1:0]  wdata_i,
  output logic                                sel_req_o,
  output logic                                sel_we_o,
  output logic [1:0]                          sel_size_o,
  output logic [ADDR_W-1:0]                   sel_addr_o,
  output logic [tsa_pkg::WORD_W-1:0]          sel_wdata_o,
  output logic [N_PORTS-1:0]                  grant_o
);
  import tsa_pkg::*;

  always_comb begin
    sel_req_o   = 1'b0;
    sel_we_o    = 1'b0;
    sel_size_o  = 2'b00;
    sel_addr_o  = '0;
    sel_wdata_o = '0;
    grant_o     = '0;
    for (int p = 0; p < int'(N_PORTS); p++) begin
      if (slot_i == SLOT_W'(p)) begin
        sel_req_o   = req_i[p];
        sel_we_o    = we_i[p];
        sel_size_o  = size_i[p*2 +: 2];
        sel_addr_o  = addr_i[p*ADDR_W +: ADDR_W];
        sel_wdata_o = wdata_i[p*WORD_W +: WORD_W];
        grant_o[p]  = req_i[p];
      end
    end
  end
endmodule

// File: rtl/tsa_ram.sv
`timescale 1ns/1ps
module tsa_ram #(
  parameter int unsigned IDX_W = 10
) (
  input  logic                        clk,
  input  logic                        en_i,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [tsa_pkg::LANES-1:0]   be_i,
  input  logic [tsa_pkg::WORD_W-1:0]  wd_i,
  output logic [tsa_pkg::WORD_W-1:0]  rd_o
);
  import tsa_pkg::*;
  localparam int unsigned DEPTH = 1 << IDX_W;

  for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
    logic [7:0] mem_q [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
      if (en_i && we_i && be_i[l]) begin
        mem_q[idx_i] <= wd_i[l*8 +: 8];
      end
    end

    always_ff @(posedge clk) begin
      if (en_i) begin
        rd_q <= mem_q[idx_i];
      end
    end

    assign rd_o[l*8 +: 8] = rd_q;
  end
endmodule

// File: rtl/tsa_arbiter.sv
`timescale 1ns/1ps
module tsa_arbiter #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [N_PORTS-1:0]                  req_i,
  input  logic [N_PORTS-1:0]                  we_i,
  input  logic [2*N_PORTS-1:0]                size_i,
  input  logic [N_PORTS*ADDR_W-1:0]           addr_i,
  input  logic [N_PORTS*tsa_pkg::WORD_W-1:0]  wdata_i,
  output logic [N_PORTS*tsa_pkg::WORD_W-1:0]  rdata_o,
  output logic [N_PORTS-1:0]                  done_o
);
  import tsa_pkg::*;

  localparam int unsigned SLOT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam int unsigned IDX_W  = ADDR_W - 2;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  // Slot rotation.
  logic [SLOT_W-1:0] slot_q;

  tsa_slot_ctr #(
    .N_PORTS (N_PORTS),
    .SLOT_W  (SLOT_W)
  ) u_slot (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .slot_o (slot_q)
  );

  // Owner selection.
  logic                sel_req;
  logic                sel_we;
  logic [1:0]          sel_size;
  logic [ADDR_W-1:0]   sel_addr;
  logic [WORD_W-1:0]   sel_wdata;
  logic [N_PORTS-1:0]  grant;

  tsa_port_mux #(
    .N_PORTS (N_PORTS),
    .ADDR_W  (ADDR_W),
    .SLOT_W  (SLOT_W)
  ) u_mux (
    .slot_i      (slot_q),
    .req_i       (req_i),
    .we_i        (we_i),
    .size_i      (size_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .sel_req_o   (sel_req),
    .sel_we_o    (sel_we),
    .sel_size_o  (sel_size),
    .sel_addr_o  (sel_addr),
    .sel_wdata_o (sel_wdata),
    .grant_o     (grant)
  );

  // Shared storage with lane steering on the write side.
  logic [LANES-1:0]  ram_be;
  logic [WORD_W-1:0] ram_wd;
  logic [WORD_W-1:0] ram_rd;

  always_comb begin
    ram_be = lane_mask(sel_size, sel_addr[1:0]);
    ram_wd = lane_spread(sel_size, sel_wdata);
  end

  tsa_ram #(
    .IDX_W (IDX_W)
  ) u_ram (
    .clk   (clk),
    .en_i  (sel_req),
    .we_i  (sel_we),
    .idx_i (sel_addr[ADDR_W-1:2]),
    .be_i  (ram_be),
    .wd_i  (ram_wd),
    .rd_o  (ram_rd)
  );

  // Completion state: next-state logic.
  logic [N_PORTS-1:0] done_q, done_d;
  logic               rd_q, rd_d;
  logic [1:0]         size_q, size_d;
  logic [1:0]         off_q, off_d;
  logic               cap_en;

  always_comb begin
    cap_en = sel_req;
    done_d = grant;
    rd_d   = sel_req & ~sel_we;
    size_d = cap_en ? sel_size      : size_q;
    off_d  = cap_en ? sel_addr[1:0] : off_q;
  end

  // Completion state: registers.
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done_q <= '0;
      rd_q   <= 1'b0;
      size_q <= 2'b00;
      off_q  <= 2'b00;
    end else begin
      done_q <= done_d;
      rd_q   <= rd_d;
      size_q <= size_d;
      off_q  <= off_d;
    end
  end

  // Read-side lane steering and per-port gating.
  logic [WORD_W-1:0] rd_pick;
  assign rd_pick = lane_pick(size_q, off_q, ram_rd);

  for (genvar p = 0; p < int'(N_PORTS); p++) begin : g_port
    assign rdata_o[p*WORD_W +: WORD_W] = (done_q[p] && rd_q) ? rd_pick : '0;
  end

  assign done_o = done_q;
endmodule

// File: rtl/tsa_arbiter_chk.sv
`timescale 1ns/1ps
module tsa_arbiter_chk #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned SLOT_W  = 3
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [N_PORTS-1:0]                  req_i,
  input logic [N_PORTS-1:0]                  done_o,
  input logic [N_PORTS*tsa_pkg::WORD_W-1:0]  rdata_o,
  input logic [SLOT_W-1:0]                   slot_q
);
  import tsa_pkg::*;
  localparam int unsigned WAIT_W = $clog2(N_PORTS + 2) + 1;

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R2: the first slot after reset belongs to core 0.
  a_r2_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (slot_q == '0));

  // R3: the slot advances by one each clock and wraps after N_PORTS.
  a_r3_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (($past(slot_q) == SLOT_W'(N_PORTS - 1)) ? (slot_q == '0)
                                                         : (slot_q == $past(slot_q) + 1'b1)));

  // R4: never more than one completion per cycle.
  a_r4_one_done: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_o));

  for (genvar p = 0; p < int'(N_PORTS); p++) begin : g_chk
    logic [WAIT_W-1:0] wait_q, wait_d;

    always_comb begin
      if (req_i[p] && !done_o[p]) begin
        wait_d = (wait_q == '1) ? wait_q : wait_q + 1'b1;
      end else begin
        wait_d = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_q <= '0;
      else        wait_q <= wait_d;
    end

    // R4: a strobe follows a slot owned by this core with its request high.
    a_r4_done_owner: assert property (@(posedge clk) disable iff (!rst_n)
      done_o[p] |-> (seen_q && $past(req_i[p]) && ($past(slot_q) == SLOT_W'(p))));

    // R5: a pending request is served within one rotation.
    a_r5_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q <= WAIT_W'(N_PORTS));

    // R9: read data stays zero without a completion.
    a_r9_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o[p] |-> (rdata_o[p*WORD_W +: WORD_W] == '0));
  end
endmodule

bind tsa_arbiter tsa_arbiter_chk #(
  .N_PORTS (N_PORTS),
  .SLOT_W  (SLOT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .req_i   (req_i),
  .done_o  (done_o),
  .rdata_o (rdata_o),
  .slot_q  (slot_q)
);

// File: tb/tsa_arbiter_bench.sv
`timescale 1ns/1ps
module tsa_arbiter_bench;
  localparam int NP  = 8;
  localparam int AW  = 12;
  localparam int WIN = 256;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     req = '0;
  logic [NP-1:0]     we = '0;
  logic [2*NP-1:0]   size = '0;
  logic [NP*AW-1:0]  addr = '0;
  logic [NP*32-1:0]  wdata = '0;
  logic [NP*32-1:0]  rdata;
  logic [NP-1:0]     done;

  tsa_arbiter #(.N_PORTS(NP), .ADDR_W(AW)) u_tsa_arbiter (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req),
    .we_i    (we),
    .size_i  (size),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .done_o  (done)
  );

  always #4 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  checks = 0;
  int  fails = 0;
  bit  finished = 0;

  logic [7:0]   mdl [WIN];
  bit           busy [NP];
  bit           hold [NP];
  bit           no_lat [NP];
  bit           was_held [NP];
  bit           prev_done [NP];
  int unsigned  launch_cyc [NP];
  int unsigned  last_done [NP];
  bit           op_we [NP];
  logic [1:0]   op_sz [NP];
  int           op_a [NP];
  logic [31:0]  op_d [NP];
  int           order_q [$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int a, input logic [1:0] sz);
    int b;
    case (sz)
      2'b00: exp_read = {24'h0, mdl[a]};
      2'b01: begin b = a & ~1; exp_read = {16'h0, mdl[b+1], mdl[b]}; end
      default: begin b = a & ~3; exp_read = {mdl[b+3], mdl[b+2], mdl[b+1], mdl[b]}; end
    endcase
  endfunction

  task automatic mdl_write(input int a, input logic [1:0] sz, input logic [31:0] d);
    int b;
    case (sz)
      2'b00: mdl[a] = d[7:0];
      2'b01: begin b = a & ~1; mdl[b] = d[7:0]; mdl[b+1] = d[15:8]; end
      default: begin
        b = a & ~3;
        mdl[b] = d[7:0]; mdl[b+1] = d[15:8]; mdl[b+2] = d[23:16]; mdl[b+3] = d[31:24];
      end
    endcase
  endtask

  task automatic launch(input int i, input bit w, input logic [1:0] sz, input int a, input logic [31:0] d);
    op_we[i] = w; op_sz[i] = sz; op_a[i] = a; op_d[i] = d;
    we[i] = w;
    size[i*2 +: 2] = sz;
    addr[i*AW +: AW] = AW'(a);
    wdata[i*32 +: 32] = d;
    req[i] = 1'b1;
    busy[i] = 1'b1;
    launch_cyc[i] = cyc;
  endtask

  task automatic step();
    logic [31:0] rd;
    logic [31:0] ex;
    int unsigned lat;
    @(negedge clk);
    // R4: one completion at most
    check($countones(done) <= 1, "R4 single done", 32'(done), 32'h1);
    for (int i = 0; i < NP; i++) begin
      rd = rdata[i*32 +: 32];
      if (prev_done[i] && !was_held[i])
        check(done[i] === 1'b0, "R5 strobe one cycle", 32'(done[i]), 32'h0);
      if (done[i] === 1'b1) begin
        order_q.push_back(i);
        if (!busy[i]) begin
          check(1'b0, "R4 unrequested done", 32'(i), 32'hFFFF_FFFF);
        end else begin
          lat = cyc - launch_cyc[i];
          if (!no_lat[i])
            check(lat >= 1 && lat <= NP, "R5 latency", lat, NP);
          if (was_held[i])
            check((cyc - last_done[i]) == NP, "R3 held spacing", cyc - last_done[i], NP);
          if (op_we[i]) begin
            check(rd === 32'h0, "R9 write completion rdata", rd, 32'h0);
            mdl_write(op_a[i], op_sz[i], op_d[i]);
          end else begin
            ex = exp_read(op_a[i], op_sz[i]);
            case (op_sz[i])
              2'b00:   check(rd === ex, "R7 byte read", rd, ex);
              2'b01:   check(rd === ex, "R8 half read", rd, ex);
              default: check(rd === ex, "R6 word read", rd, ex);
            endcase
          end
          last_done[i] = cyc;
          was_held[i] = hold[i];
          no_lat[i] = 1'b0;
          if (hold[i]) begin
            launch_cyc[i] = cyc;
          end else begin
            req[i] = 1'b0;
            busy[i] = 1'b0;
          end
        end
      end else begin
        check(rd === 32'h0, "R9 idle rdata", rd, 32'h0);
      end
      prev_done[i] = done[i];
    end
  endtask

  function automatic bit any_busy();
    any_busy = 1'b0;
    for (int i = 0; i < NP; i++) if (busy[i]) any_busy = 1'b1;
  endfunction

  task automatic drain();
    for (int k = 0; k < 4*NP && any_busy(); k++) step();
    check(!any_busy(), "R5 drain", 32'(any_busy()), 32'h0);
  endtask

  initial begin
    void'($urandom(32'd20240613));
    for (int i = 0; i < NP; i++) begin
      busy[i] = 0; hold[i] = 0; no_lat[i] = 0; was_held[i] = 0; prev_done[i] = 0;
    end
    for (int b = 0; b < WIN; b++) mdl[b] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: quiet outputs under reset
    check(done === '0, "R1 done in reset", 32'(done), 32'h0);
    check(rdata === '0, "R1 rdata in reset", rdata[31:0], 32'h0);

    // R2: all cores pending at release; core 0 must finish first, then in order
    for (int i = 0; i < NP; i++) begin
      launch(i, 1'b1, 2'b10, i*4, 32'hA500_0000 | 32'(i));
      no_lat[i] = 1'b1;
    end
    @(negedge clk);
    check(done === '0, "R1 done in reset with requests", 32'(done), 32'h0);
    rst_n = 1'b1;
    order_q.delete();
    drain();
    check(order_q.size() == NP, "R2 service count", order_q.size(), NP);
    for (int j = 0; j < NP && j < order_q.size(); j++)
      check(order_q[j] == j, "R2 slot order", order_q[j], j);

    // Fill the exercised window with known words
    for (int b = 0; b < WIN/4; b += NP) begin
      for (int i = 0; i < NP; i++) launch(i, 1'b1, 2'b10, (b+i)*4, $urandom);
      drain();
    end

    // R7: byte writes into each lane, then word and byte reads
    for (int k = 0; k < 4; k++) begin
      launch(2, 1'b1, 2'b00, 8'h40 + k, 32'hFFFF_FF10 + 32'(k));
      drain();
    end
    launch(5, 1'b0, 2'b10, 8'h40, 0); drain();
    for (int k = 0; k < 4; k++) begin
      launch(6, 1'b0, 2'b00, 8'h40 + k, 0); drain();
    end

    // R8: halfword writes with bit 0 set, reads of both halves
    launch(1, 1'b1, 2'b01, 8'h51, 32'hDEAD_BEEF); drain();
    launch(4, 1'b1, 2'b01, 8'h53, 32'h1234_CAFE); drain();
    launch(0, 1'b0, 2'b10, 8'h50, 0); drain();
    launch(7, 1'b0, 2'b01, 8'h52, 0); drain();
    launch(7, 1'b0, 2'b01, 8'h51, 0); drain();

    // R6: word write with misaligned low bits, size 11 read
    launch(3, 1'b1, 2'b10, 8'h63, 32'h0BAD_F00D); drain();
    launch(2, 1'b0, 2'b10, 8'h60, 0); drain();
    launch(6, 1'b0, 2'b11, 8'h61, 0); drain();

    // R3: a held request completes once per rotation
    hold[3] = 1'b1;
    launch(3, 1'b0, 2'b10, 8'h40, 0);
    repeat (3*NP + 2) step();
    hold[3] = 1'b0;
    drain();

    // Random mix of cores, sizes, phases (R5, R6, R7, R8)
    for (int it = 0; it < 600; it++) begin
      for (int i = 0; i < NP; i++) begin
        if (!busy[i] && ($urandom % 3 == 0))
          launch(i, 1'($urandom), 2'($urandom), int'($urandom % WIN), $urandom);
      end
      step();
    end
    drain();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule